// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This engine moves outgoing frames from memory to a byte stream. Software places 32-byte buffer descriptors in a ring and hands each one over by setting its ready flag. A start pulse makes the engine fetch descriptors from its current ring position. For each ready descriptor it copies the referenced buffer into an internal frame store. When a descriptor marks the end of a frame, the whole frame is sent on a byte-wide valid/ready stream. Each descriptor is then written back with its ready flag cleared, and the engine moves on to the next slot.

All memory traffic goes through a single word-wide request/acknowledge port, and a read's data is taken in the cycle its acknowledge arrives. A frame never grows beyond 2032 bytes. Bytes past that limit are dropped and a babbling-transmit event is raised. Buffer and frame events are enabled separately in each descriptor's option field. A walk stops at the first descriptor that is not ready. That descriptor's address is kept, so the next start resumes from it.

Top module: `tdr_engine`

## Requirements
- R1: After reset, `busy_o`, `mem_req_o`, `tx_valid_o` and all three event outputs are low.
- R2: A descriptor at address D is fetched as three word reads at D, D+4 and D+8. Word D holds the length in bits 15:0 and the flags in bits 31:16, with the ready flag at bit 31. If the ready flag is clear, the walk ends with no write, and the next start fetches D again. A request is held with a stable address until it is acknowledged.
- R3: The buffer address is the word at D+4 and is a byte address. Bytes are little-endian within each memory word. The buffers of a frame are joined in ring order and streamed in that order once the descriptor with the last flag (word bit 27) has been copied. `tx_last_o` marks the final byte of the frame.
- R4: If the bytes already gathered plus a buffer's length would exceed 2032, only the bytes up to 2032 are kept and `evt_babt_o` pulses once for that descriptor.
- R5: If the TX-interrupt option bit (bit 30 of the word at D+8) is set, `evt_txb_o` pulses once for that descriptor. If that descriptor also carries the last flag, `evt_txf_o` pulses in the same cycle. If the option bit is clear, neither event pulses.
- R6: After a descriptor is processed, and after its frame has been streamed when it is the last one, the word at D is written back unchanged except that bit 31 is cleared.
- R7: If the wrap flag (word bit 29) is set, the next descriptor is read at the ring base with its three low bits forced to zero. Otherwise it is read at D+32. A base load while idle moves the ring position to that aligned base.
- R8: A start pulse that arrives while a walk is in progress is remembered, and a new walk begins from the stop position once the current walk ends.
- R9: While `tx_valid_o` is high and `tx_ready_i` is low, the data and last outputs hold steady and valid stays high.
- R10: Each walk begins with an empty frame. Buffers gathered without a last flag before a walk stops are never streamed. A last descriptor that ends a zero-byte frame streams nothing but is still written back and still raises its events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that begins a ring walk |
| base_load_i | input | 1 | Pulse that moves the ring position to the base when idle |
| ring_base_i | input | 32 | Ring base address (low three bits ignored) |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Word-aligned memory byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge; read data valid in this cycle |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_data_o | output | 8 | Stream byte |
| tx_last_o | output | 1 | Final byte of the frame |
| tx_ready_i | input | 1 | Stream sink ready |
| evt_txb_o | output | 1 | TX buffer event pulse |
| evt_txf_o | output | 1 | TX frame event pulse |
| evt_babt_o | output | 1 | Babbling-transmit event pulse |
| busy_o | output | 1 | A walk is in progress |

## Verification
The engine is tested on several rings:
- A three-slot ring with odd buffer addresses, a split frame and a wrap from a misaligned base. This shows whether byte lanes, concatenation and wrap alignment are handled correctly.
- A two-buffer frame of 2100 bytes. This separates saturation at 2032 from plain truncation and from a missing babble pulse.
- A walk that stops mid-frame, followed by a walk that finishes with a zero-length last buffer. This shows whether partial frames are dropped and whether empty frames still produce write-back and events.
- A second start pulse issued during a long copy. This shows whether the engine re-fetches the stop descriptor, which tells a remembered start apart from a lost one.

Memory stalls and sink back-pressure are random throughout. Every streamed byte and every write-back is compared against a behavioural model of the ring.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  localparam int unsigned FLG_READY = 15;
  localparam int unsigned FLG_WRAP  = 13;
  localparam int unsigned FLG_LAST  = 11;
  localparam int unsigned OPT_IRQ   = 14;

  typedef enum logic [2:0] {
    W_IDLE,
    W_HDR,
    W_PTR,
    W_OPT,
    W_RDBUF,
    W_WRBYTE,
    W_SEND,
    W_WBACK
  } walk_st_e;
endpackage

// File: rtl/tdr_fbuf.sv
module tdr_fbuf #(
  parameter int DEPTH = 2032,
  parameter int IW    = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/tdr_stream.sv
module tdr_stream #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [LEN_W-1:0] go_len,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic             tx_last,
  output logic [LEN_W-1:0] rd_idx,
  output logic             done
);
  logic             act_q, act_d;
  logic [LEN_W-1:0] idx_q, idx_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             fire;

  assign tx_valid = act_q;
  assign tx_last  = act_q && (idx_q == LEN_W'(len_q - LEN_W'(1)));
  assign rd_idx   = idx_q;
  assign fire     = act_q && tx_ready;
  assign done     = fire && tx_last;

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    len_d = len_q;
    if (go) begin
      act_d = 1'b1;
      idx_d = '0;
      len_d = go_len;
    end else if (fire) begin
      if (tx_last) act_d = 1'b0;
      else         idx_d = idx_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
      len_q <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
      len_q <= len_d;
    end
  end
endmodule

// File: rtl/tdr_walker.sv
module tdr_walker
  import tdr_pkg::*;
#(
  parameter int FRAME_MAX  = 2032,
  parameter int DESC_BYTES = 32,
  parameter int BASE_ALIGN = 8,
  parameter int LEN_W      = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             base_load,
  input  logic [31:0]      ring_base,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             fb_we,
  output logic [LEN_W-1:0] fb_waddr,
  output logic [7:0]       fb_wdata,
  output logic             sd_go,
  output logic [LEN_W-1:0] sd_len,
  input  logic             sd_done,
  output logic             evt_txb,
  output logic             evt_txf,
  output logic             evt_babt,
  output logic             busy
);
  localparam logic [31:0] BASE_MASK = ~(32'(BASE_ALIGN) - 32'd1);

  walk_st_e         st_q, st_d;
  logic [31:0]      desc_q, desc_d;
  logic [15:0]      len_q, len_d;
  logic [15:0]      flg_q, flg_d;
  logic [31:0]      bptr_q, bptr_d;
  logic             irq_q, irq_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [LEN_W-1:0] flen_q, flen_d;
  logic [31:0]      word_q, word_d;
  logic             pend_q, pend_d;
  logic             txb_q, txb_d, txf_q, txf_d, babt_q, babt_d;

  logic [31:0]      base_al;
  logic [16:0]      sum;
  logic             over;
  logic [LEN_W-1:0] room, take;
  logic             fin;
  logic [LEN_W-1:0] fin_len;
  logic [15:0]      flg_clr;
  logic [31:0]      word_sh;

  assign base_al  = ring_base & BASE_MASK;
  assign sum      = 17'(flen_q) + 17'(len_q);
  assign over     = sum > 17'(FRAME_MAX);
  assign room     = LEN_W'(FRAME_MAX) - flen_q;
  assign take     = over ? room : len_q[LEN_W-1:0];
  assign word_sh  = word_q >> {bptr_q[1:0], 3'b000};
  assign busy     = (st_q != W_IDLE);
  assign evt_txb  = txb_q;
  assign evt_txf  = txf_q;
  assign evt_babt = babt_q;

  always_comb begin
    flg_clr            = flg_q;
    flg_clr[FLG_READY] = 1'b0;
  end

  always_comb begin
    st_d   = st_q;   desc_d = desc_q; len_d  = len_q;  flg_d  = flg_q;
    bptr_d = bptr_q; irq_d  = irq_q;  rem_d  = rem_q;  flen_d = flen_q;
    word_d = word_q; pend_d = pend_q;
    txb_d  = 1'b0;   txf_d  = 1'b0;   babt_d = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_q;
    mem_wdata = '0;
    fb_we     = 1'b0;
    fb_waddr  = flen_q;
    fb_wdata  = word_sh[7:0];
    sd_go     = 1'b0;
    sd_len    = flen_q;
    fin       = 1'b0;
    fin_len   = flen_q;

    if (start && (st_q != W_IDLE)) pend_d = 1'b1;

    case (st_q)
      W_IDLE: begin
        if (base_load) desc_d = base_al;
        if (start || pend_q) begin
          st_d   = W_HDR;
          flen_d = '0;
          pend_d = 1'b0;
        end
      end
      W_HDR: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          if (!mem_rdata[16+FLG_READY]) begin
            st_d = W_IDLE;
          end else begin
            len_d = mem_rdata[15:0];
            flg_d = mem_rdata[31:16];
            st_d  = W_PTR;
          end
        end
      end
      W_PTR: begin
        mem_req  = 1'b1;
        mem_addr = desc_q + 32'd4;
        if (mem_ack) begin
          bptr_d = mem_rdata;
          st_d   = W_OPT;
        end
      end
      W_OPT: begin
        mem_req  = 1'b1;
        mem_addr = desc_q + 32'd8;
        if (mem_ack) begin
          irq_d  = mem_rdata[16+OPT_IRQ];
          babt_d = over;
          rem_d  = take;
          if (take == '0) fin = 1'b1;
          else            st_d = W_RDBUF;
        end
      end
      W_RDBUF: begin
        mem_req  = 1'b1;
        mem_addr = {bptr_q[31:2], 2'b00};
        if (mem_ack) begin
          word_d = mem_rdata;
          st_d   = W_WRBYTE;
        end
      end
      W_WRBYTE: begin
        fb_we  = 1'b1;
        bptr_d = bptr_q + 32'd1;
        flen_d = flen_q + LEN_W'(1);
        rem_d  = rem_q - LEN_W'(1);
        if (rem_q == LEN_W'(1)) begin
          fin     = 1'b1;
          fin_len = flen_q + LEN_W'(1);
        end else if (bptr_q[1:0] == 2'd3) begin
          st_d = W_RDBUF;
        end
      end
      W_SEND: begin
        if (sd_done) st_d = W_WBACK;
      end
      W_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {flg_clr, len_q};
        if (mem_ack) begin
          txb_d  = irq_q;
          txf_d  = irq_q && flg_q[FLG_LAST];
          desc_d = flg_q[FLG_WRAP] ? base_al : desc_q + 32'(DESC_BYTES);
          st_d   = W_HDR;
        end
      end
      default: st_d = W_IDLE;
    endcase

    if (fin) begin
      if (flg_q[FLG_LAST]) begin
        flen_d = '0;
        if (fin_len != '0) begin
          sd_go  = 1'b1;
          sd_len = fin_len;
          st_d   = W_SEND;
        end else begin
          st_d = W_WBACK;
        end
      end else begin
        flen_d = fin_len;
        st_d   = W_WBACK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      desc_q <= '0;  len_q  <= '0; flg_q <= '0; bptr_q <= '0;
      irq_q  <= 1'b0; rem_q <= '0; flen_q <= '0; word_q <= '0;
      pend_q <= 1'b0; txb_q <= 1'b0; txf_q <= 1'b0; babt_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      desc_q <= desc_d; len_q <= len_d; flg_q <= flg_d; bptr_q <= bptr_d;
      irq_q  <= irq_d;  rem_q <= rem_d; flen_q <= flen_d; word_q <= word_d;
      pend_q <= pend_d; txb_q <= txb_d; txf_q <= txf_d; babt_q <= babt_d;
    end
  end
endmodule

// File: rtl/tdr_engine.sv
module tdr_engine #(
  parameter int FRAME_MAX  = 2032,
  parameter int DESC_BYTES = 32,
  parameter int BASE_ALIGN = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        base_load_i,
  input  logic [31:0] ring_base_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_ack_i,
  input  logic [31:0] mem_rdata_i,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_last_o,
  input  logic        tx_ready_i,
  output logic        evt_txb_o,
  output logic        evt_txf_o,
  output logic        evt_babt_o,
  output logic        busy_o
);
  localparam int LEN_W = $clog2(FRAME_MAX + 1);

  logic             fb_we;
  logic [LEN_W-1:0] fb_waddr, rd_idx, sd_len;
  logic [7:0]       fb_wdata;
  logic             sd_go, sd_done;

  tdr_walker #(
    .FRAME_MAX(FRAME_MAX), .DESC_BYTES(DESC_BYTES),
    .BASE_ALIGN(BASE_ALIGN), .LEN_W(LEN_W)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start_i), .base_load(base_load_i),
    .ring_base(ring_base_i),
    .mem_req(mem_req_o), .mem_we(mem_we_o), .mem_addr(mem_addr_o),
    .mem_wdata(mem_wdata_o), .mem_ack(mem_ack_i), .mem_rdata(mem_rdata_i),
    .fb_we(fb_we), .fb_waddr(fb_waddr), .fb_wdata(fb_wdata),
    .sd_go(sd_go), .sd_len(sd_len), .sd_done(sd_done),
    .evt_txb(evt_txb_o), .evt_txf(evt_txf_o), .evt_babt(evt_babt_o),
    .busy(busy_o)
  );

  tdr_fbuf #(.DEPTH(FRAME_MAX), .IW(LEN_W)) u_fbuf (
    .clk(clk), .we(fb_we), .waddr(fb_waddr), .wdata(fb_wdata),
    .raddr(rd_idx), .rdata(tx_data_o)
  );

  tdr_stream #(.LEN_W(LEN_W)) u_strm (
    .clk(clk), .rst_n(rst_n), .go(sd_go), .go_len(sd_len),
    .tx_ready(tx_ready_i), .tx_valid(tx_valid_o), .tx_last(tx_last_o),
    .rd_idx(rd_idx), .done(sd_done)
  );
endmodule

// File: rtl/tdr_engine_chk.sv
module tdr_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_ack_i,
  input logic        tx_valid_o,
  input logic [7:0]  tx_data_o,
  input logic        tx_last_o,
  input logic        tx_ready_i,
  input logic        evt_txb_o,
  input logic        evt_txf_o,
  input logic        busy_o
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o && !tx_valid_o);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  // R3
  stream_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> busy_o);
  // R5
  txf_with_txb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_txf_o |-> evt_txb_o);
  // R6
  wb_ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> !mem_wdata_o[31]);
  // R7
  wb_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> mem_addr_o[2:0] == 3'b000);
  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));
endmodule

bind tdr_engine tdr_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
  .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_last_o(tx_last_o),
  .tx_ready_i(tx_ready_i), .evt_txb_o(evt_txb_o), .evt_txf_o(evt_txf_o),
  .busy_o(busy_o)
);

// File: tb/tdr_engine_tb.sv
module tdr_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 4096;
  localparam int FMAX       = 2032;

  logic        clk, rst_n, start, base_load;
  logic [31:0] ring_base;
  logic        mem_req, mem_we, mem_ack, stall;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_last, tx_ready;
  logic [7:0]  tx_data;
  logic        evt_txb, evt_txf, evt_babt, busy;

  logic [31:0] mem [MEM_WORDS];
  logic [31:0] sh  [MEM_WORDS];
  logic [8:0]  exp_b [$];
  logic [31:0] exp_wa [$];
  logic [31:0] exp_wd [$];
  int n_chk, n_fail, cyc;
  int e_txb, e_txf, e_babt, n_txb, n_txf, n_babt;
  int watch_cnt;
  logic [31:0] watch_addr, exp_first, model_desc, model_base;
  logic want_first, hold_q, hl;
  logic [7:0] hd;

  tdr_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .base_load_i(base_load),
    .ring_base_i(ring_base), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .tx_last_o(tx_last), .tx_ready_i(tx_ready), .evt_txb_o(evt_txb),
    .evt_txf_o(evt_txf), .evt_babt_o(evt_babt), .busy_o(busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr[13:2]];
  assign mem_ack   = mem_req && !stall;

  always @(posedge clk) begin
    if (mem_req && mem_ack && mem_we) mem[mem_addr[13:2]] <= mem_wdata;
  end

  always @(posedge clk) begin
    #1;
    stall    = ($urandom % 3) == 0;
    tx_ready = ($urandom % 4) != 0;
  end

  task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid && tx_ready) begin
        if (exp_b.size() == 0) chk(1'b0, "R3 unexpected stream byte", {23'd0, tx_last, tx_data}, 32'd0);
        else begin
          logic [8:0] e;
          e = exp_b.pop_front();
          chk({tx_last, tx_data} == e, "R3 stream byte/last", {23'd0, tx_last, tx_data}, {23'd0, e});
        end
      end
      if (hold_q) chk(tx_valid && tx_data == hd && tx_last == hl, "R9 stalled byte held",
                      {23'd0, tx_last, tx_data}, {23'd0, hl, hd});
      hold_q = tx_valid && !tx_ready;
      hd = tx_data;
      hl = tx_last;
      if (mem_req && mem_ack && mem_we) begin
        if (exp_wa.size() == 0) chk(1'b0, "R6 unexpected write-back", mem_addr, 32'd0);
        else begin
          logic [31:0] a, d;
          a = exp_wa.pop_front();
          d = exp_wd.pop_front();
          chk(mem_addr == a, "R7 write-back address", mem_addr, a);
          chk(mem_wdata == d, "R6 write-back data", mem_wdata, d);
        end
      end
      if (mem_req && mem_ack && !mem_we) begin
        if (want_first) begin
          chk(mem_addr == exp_first, "R2 first fetch address", mem_addr, exp_first);
          want_first = 1'b0;
        end
        if (mem_addr == watch_addr) watch_cnt++;
      end
      n_txb  += int'(evt_txb);
      n_txf  += int'(evt_txf);
      n_babt += int'(evt_babt);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired (R1..R10 run hung) actual=%0d expected<%0d", cyc, cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    mem[a[13:2]] <= d;
  endtask

  task automatic put_desc(input logic [31:0] d, input logic [15:0] len, input logic [15:0] flg,
                          input logic [31:0] bp, input logic irq);
    wr(d, {flg, len});
    wr(d + 4, bp);
    wr(d + 8, {1'b0, irq, 30'd0});
  endtask

  function automatic logic [7:0] shb(input logic [31:0] a);
    logic [31:0] w;
    w = sh[a[13:2]] >> (8 * a[1:0]);
    return w[7:0];
  endfunction

  task automatic expect_walk();
    logic [31:0] d, w0, bp, ow;
    logic [15:0] fg;
    logic [8:0]  fr [$];
    int fl, n;
    #1;
    for (int i = 0; i < MEM_WORDS; i++) sh[i] = mem[i];
    exp_first = model_desc; want_first = 1'b1;
    e_txb = 0; e_txf = 0; e_babt = 0; n_txb = 0; n_txf = 0; n_babt = 0;
    d = model_desc; fl = 0;
    for (int k = 0; k < 64; k++) begin
      w0 = sh[d[13:2]];
      if (!w0[31]) break;
      fg = w0[31:16];
      bp = sh[d[13:2] + 12'd1];
      ow = sh[d[13:2] + 12'd2];
      n  = int'(w0[15:0]);
      if (fl + n > FMAX) begin n = FMAX - fl; e_babt++; end
      for (int j = 0; j < n; j++) fr.push_back({1'b0, shb(bp + 32'(j))});
      fl += n;
      if (fg[11]) begin
        if (fr.size() > 0) fr[fr.size()-1][8] = 1'b1;
        foreach (fr[j]) exp_b.push_back(fr[j]);
        fr.delete();
        fl = 0;
      end
      if (ow[30]) begin e_txb++; if (fg[11]) e_txf++; end
      sh[d[13:2]] = w0 & 32'h7FFF_FFFF;
      exp_wa.push_back(d);
      exp_wd.push_back(w0 & 32'h7FFF_FFFF);
      d = fg[13] ? model_base : d + 32'd32;
    end
    model_desc = d;
  endtask

  task automatic pulse_start();
    @(posedge clk); #2; start = 1'b1;
    @(posedge clk); #2; start = 1'b0;
  endtask

  task automatic load_base(input logic [31:0] b);
    @(posedge clk); #2; ring_base = b; base_load = 1'b1;
    @(posedge clk); #2; base_load = 1'b0;
    model_base = b & 32'hFFFF_FFF8;
    model_desc = model_base;
  endtask

  task automatic wait_idle();
    int quiet;
    quiet = 0;
    while (quiet < 4) begin
      @(negedge clk);
      quiet = busy ? 0 : quiet + 1;
    end
  endtask

  task automatic end_walk(input string tag);
    chk(exp_b.size() == 0, {tag, " R3 all bytes streamed"}, exp_b.size(), 0);
    chk(exp_wa.size() == 0, {tag, " R6 all write-backs seen"}, exp_wa.size(), 0);
    chk(n_txb == e_txb, {tag, " R5 buffer events"}, n_txb, e_txb);
    chk(n_txf == e_txf, {tag, " R5 frame events"}, n_txf, e_txf);
    chk(n_babt == e_babt, {tag, " R4 babble events"}, n_babt, e_babt);
  endtask

  task automatic run_walk(input string tag);
    expect_walk();
    pulse_start();
    wait_idle();
    end_walk(tag);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0;
    rst_n = 1'b0; start = 1'b0; base_load = 1'b0; ring_base = '0;
    stall = 1'b0; tx_ready = 1'b1; hold_q = 1'b0; hd = '0; hl = 1'b0;
    want_first = 1'b0; watch_addr = 32'hFFFF_FFFF; watch_cnt = 0;
    model_desc = '0; model_base = '0;
    for (int i = 0; i < MEM_WORDS; i++) mem[i] <= (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_1234;
    repeat (3) @(posedge clk);
    #2; rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy, "R1 busy after reset", {31'd0, busy}, 0);
    chk(!mem_req, "R1 mem_req after reset", {31'd0, mem_req}, 0);
    chk(!tx_valid, "R1 tx_valid after reset", {31'd0, tx_valid}, 0);
    chk(!(evt_txb | evt_txf | evt_babt), "R1 events after reset", {29'd0, evt_txb, evt_txf, evt_babt}, 0);

    // R3 R7: odd buffer addresses, split frame, wrap from misaligned base
    load_base(32'h105);
    put_desc(32'h100, 16'd5, 16'h8800, 32'h1001, 1'b1);
    put_desc(32'h120, 16'd7, 16'h8000, 32'h1102, 1'b0);
    put_desc(32'h140, 16'd3, 16'hA800, 32'h1203, 1'b1);
    run_walk("ring1");

    // R2: resume from stop descriptor
    put_desc(32'h100, 16'd1, 16'h8800, 32'h1300, 1'b1);
    run_walk("resume");

    // R4: saturation at 2032 bytes
    load_base(32'h800);
    put_desc(32'h800, 16'd2000, 16'h8000, 32'h2000, 1'b1);
    put_desc(32'h820, 16'd100, 16'hA800, 32'h3000, 1'b1);
    run_walk("babble");

    // R10: partial frame dropped at stop, then zero-length last
    load_base(32'hA00);
    put_desc(32'hA00, 16'd4, 16'h8000, 32'h1400, 1'b0);
    wr(32'hA20, 32'd0);
    run_walk("partial");
    put_desc(32'hA20, 16'd6, 16'h8800, 32'h1500, 1'b1);
    put_desc(32'hA40, 16'd0, 16'hA800, 32'h1580, 1'b1);
    run_walk("restart");

    // R8: start during busy is remembered
    load_base(32'hC00);
    put_desc(32'hC00, 16'd300, 16'h8800, 32'h1600, 1'b1);
    wr(32'hC20, 32'd0);
    expect_walk();
    watch_addr = 32'hC20; watch_cnt = 0;
    pulse_start();
    repeat (10) @(posedge clk);
    chk(busy, "R8 busy during long copy", {31'd0, busy}, 1);
    pulse_start();
    wait_idle();
    end_walk("pending");
    chk(watch_cnt == 2, "R8 stop descriptor fetched again", watch_cnt, 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule